// File: doc/BRIEF.md
# Power Mode Controller

This block holds the power-control byte of a small processor core and turns it into three clock enables: one for the CPU core clock, one for the peripheral clocks and one for the oscillator. Software writes the byte to request a light sleep (idle), in which only the CPU clock stops, or a deep sleep (power-down), in which the oscillator enable drops and every clock stops. The same byte carries two general-purpose user flags and a stored auxiliary bit that no logic here acts on.

Idle ends when the interrupt controller reports an enabled interrupt pending. Power-down ends only through reset. A parameter selects a guarded variant. In that variant a mode is entered only by an arm write followed at once by a confirm write, so a single stray write cannot stop the core.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, rd_data reads 0x00 and cpu_clk_en, per_clk_en and osc_en are all 1.
- R2: In the plain variant, a write with bit 0 set and bit 1 clear enters idle on the next cycle: rd_data bit 0 reads 1, cpu_clk_en is 0, and per_clk_en and osc_en stay 1.
- R3: A write that enters power-down sets rd_data bit 1 and drives cpu_clk_en, per_clk_en and osc_en to 0 on the next cycle. In the plain variant this is any write with bit 1 set.
- R4: When one write requests both idle and power-down, only power-down takes effect. Bit 1 reads 1 and bit 0 reads 0.
- R5: While idle, irq_pending high at a clock edge clears idle. On the next cycle rd_data bit 0 reads 0 and cpu_clk_en is 1.
- R6: While in power-down, irq_pending has no effect. Only rst_n low leaves power-down.
- R7: Writes are ignored while cpu_clk_en is 0, which covers both idle and power-down.
- R8: A write stores bits 2 and 3 (user flags) and bit 7 (auxiliary bit), and they read back at the same positions. Bits 6 to 4 always read 0.
- R9: The user flags keep their values across an exit from idle and are cleared by reset.
- R10: In the guarded variant, a write with the enable bit set and the confirm bit clear arms a mode. If the very next write has the enable bit clear and the confirm bit set, that mode is entered. Idle uses enable bit 0 and confirm bit 4. Power-down uses enable bit 1 and confirm bit 5.
- R11: In the guarded variant, no other sequence enters a mode. This covers a lone arm write, a confirm without an arm, an arm followed by any other write, and a write with enable and confirm both set. Each of these leaves the mode bits at 0 and all enables at 1.
- R12: In the guarded variant, when both modes are armed and both are confirmed in one write, power-down takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte written to the control register |
| irq_pending | input | 1 | An enabled interrupt is pending |
| rd_data | output | 8 | Current register value |
| cpu_clk_en | output | 1 | CPU core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The assertions assume that the block's own clock keeps running in both sleep modes. They also assume that irq_pending is a level that the interrupt logic holds at least one cycle. The stimulus keeps within these assumptions. It raises each write and each interrupt for exactly one clock, spaced by idle cycles, and it raises irq_pending only while the model expects the core to sleep or to run, never in the middle of a reset. The guarded sequences are driven as back-to-back writes, and a gap cycle with no write does not break a sequence.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   localparam int REG_W    = 8;
   localparam int IDLE_BIT = 0;
   localparam int PD_BIT   = 1;
   localparam int UF_LO    = 2;
   localparam int UF_W     = 2;
   localparam int AUX_BIT  = 7;
   localparam int IDLE_CF  = 4;
   localparam int PD_CF    = 5;
   localparam int N_MODES  = 2;
endpackage

// File: rtl/pwr_entry_seq.sv
module pwr_entry_seq
   import pwr_mode_pkg::*;
#(
   parameter bit GUARDED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_acc,
   input  logic [REG_W-1:0] wr_data,
   output logic             idle_req,
   output logic             pd_req
);
   logic [N_MODES-1:0] req;

   generate
      if (GUARDED) begin : g_guard
         for (genvar m = 0; m < N_MODES; m++) begin : g_mode
            localparam int EN_P = (m == 0) ? IDLE_BIT : PD_BIT;
            localparam int CF_P = (m == 0) ? IDLE_CF  : PD_CF;
            logic arm_q;
            always_ff @(posedge clk) begin
               if (!rst_n)      arm_q <= 1'b0;
               else if (wr_acc) arm_q <= wr_data[EN_P] & ~wr_data[CF_P];
            end
            assign req[m] = wr_acc & arm_q & ~wr_data[EN_P] & wr_data[CF_P];
         end
      end else begin : g_plain
         assign req[0] = wr_acc & wr_data[IDLE_BIT];
         assign req[1] = wr_acc & wr_data[PD_BIT];
      end
   endgenerate

   assign idle_req = req[0];
   assign pd_req   = req[1];
endmodule

// File: rtl/pwr_mode_state.sv
module pwr_mode_state (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   input  logic pd_req,
   input  logic irq_pending,
   output logic idle_q,
   output logic pd_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (pd_q) begin
         idle_q <= 1'b0;
      end else if (pd_req) begin
         pd_q   <= 1'b1;
         idle_q <= 1'b0;
      end else if (idle_req) begin
         idle_q <= 1'b1;
      end else if (irq_pending) begin
         idle_q <= 1'b0;
      end
   end

   AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |=> pd_q); // R6
   AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && irq_pending) |=> !idle_q); // R5
   AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(idle_q && pd_q)); // R4
endmodule

// File: rtl/pwr_user_bits.sv
module pwr_user_bits
   import pwr_mode_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_acc,
   input  logic [REG_W-1:0] wr_data,
   output logic [UF_W-1:0] uf_q,
   output logic            aux_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uf_q  <= '0;
         aux_q <= 1'b0;
      end else if (wr_acc) begin
         uf_q  <= wr_data[UF_LO +: UF_W];
         aux_q <= wr_data[AUX_BIT];
      end
   end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pwr_mode_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit GUARDED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_pending,
   output logic [DATA_W-1:0] rd_data,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              osc_en
);
   localparam int SPARE_LO = UF_LO + UF_W;
   localparam int SPARE_W  = AUX_BIT - SPARE_LO;

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("pwr_mode_ctl: DATA_W must equal REG_W");
      end
   endgenerate

   logic            wr_acc;
   logic            idle_req, pd_req;
   logic            idle_q, pd_q;
   logic [UF_W-1:0] uf_q;
   logic            aux_q;

   assign wr_acc = wr_en & cpu_clk_en;

   pwr_entry_seq #(.GUARDED(GUARDED)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(wr_data),
      .idle_req(idle_req), .pd_req(pd_req));

   pwr_mode_state u_state (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pd_req(pd_req),
      .irq_pending(irq_pending), .idle_q(idle_q), .pd_q(pd_q));

   pwr_user_bits u_bits (
      .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(wr_data),
      .uf_q(uf_q), .aux_q(aux_q));

   assign rd_data    = {aux_q, {SPARE_W{1'b0}}, uf_q, pd_q, idle_q};
   assign cpu_clk_en = ~(idle_q | pd_q);
   assign per_clk_en = ~pd_q;
   assign osc_en     = ~pd_q;

   AST_OSC_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!cpu_clk_en && !per_clk_en)); // R3
   AST_SLEEP_HOLDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en |=> $stable(uf_q) && $stable(aux_q)); // R7
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[AUX_BIT-1:SPARE_LO] == '0); // R8
endmodule

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      bit         sel;
      logic [7:0] rd;
      logic [2:0] en;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en_p = 1'b0, wr_en_g = 1'b0;
   logic [7:0] wd_p = '0, wd_g = '0;
   logic irq_p = 1'b0, irq_g = 1'b0;
   logic [7:0] rd_p, rd_g;
   logic cpu_p, per_p, osc_p, cpu_g, per_g, osc_g;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctl #(.GUARDED(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_p), .wr_data(wd_p),
      .irq_pending(irq_p), .rd_data(rd_p),
      .cpu_clk_en(cpu_p), .per_clk_en(per_p), .osc_en(osc_p));

   pwr_mode_ctl #(.GUARDED(1'b1)) uut_grd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_g), .wr_data(wd_g),
      .irq_pending(irq_g), .rd_data(rd_g),
      .cpu_clk_en(cpu_g), .per_clk_en(per_g), .osc_en(osc_g));

   // monitor: compares one expected item per falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() != 0) begin
            exp_t e;
            logic [7:0] rd;
            logic [2:0] en;
            e = q.pop_front();
            rd = e.sel ? rd_g : rd_p;
            en = e.sel ? {cpu_g, per_g, osc_g} : {cpu_p, per_p, osc_p};
            total++;
            if (rd !== e.rd || en !== e.en) begin
               bad++;
               $display("FAIL %s: rd=%h en=%b expected rd=%h en=%b",
                        e.tag, rd, en, e.rd, e.en);
            end
         end
      end
   end

   // en order is {cpu, per, osc}
   task automatic step(input bit sel, input bit wr, input logic [7:0] d,
                       input bit irq, input logic [7:0] erd,
                       input logic [2:0] een, input string tag);
      exp_t e;
      @(negedge clk);
      if (sel) begin wr_en_g = wr; wd_g = d; irq_g = irq; end
      else     begin wr_en_p = wr; wd_p = d; irq_p = irq; end
      @(posedge clk);
      e.sel = sel; e.rd = erd; e.en = een; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      wr_en_p = 1'b0; wr_en_g = 1'b0; irq_p = 1'b0; irq_g = 1'b0;
   endtask

   task automatic do_reset(input string tag);
      exp_t e;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      e.sel = 1'b0; e.rd = 8'h00; e.en = 3'b111; e.tag = tag;
      q.push_back(e);
      e.sel = 1'b1;
      q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: rd=%h expected completion", rd_p);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset("R1 reset state");
      // plain variant
      step(0, 1, 8'h8C, 0, 8'h8C, 3'b111, "R8 flags and aux stored");
      step(0, 1, 8'hFC, 0, 8'h8C, 3'b111, "R8 bits 6:4 read zero");
      step(0, 1, 8'h8D, 0, 8'h8D, 3'b011, "R2 idle entry");
      step(0, 1, 8'h00, 0, 8'h8D, 3'b011, "R7 write ignored in idle");
      step(0, 0, 8'h00, 1, 8'h8C, 3'b111, "R5 R9 irq wakes, flags kept");
      step(0, 0, 8'h00, 1, 8'h8C, 3'b111, "R5 irq while running no effect");
      step(0, 1, 8'h0E, 0, 8'h0E, 3'b000, "R3 power-down entry");
      step(0, 0, 8'h00, 1, 8'h0E, 3'b000, "R6 irq ignored in power-down");
      step(0, 1, 8'h01, 0, 8'h0E, 3'b000, "R7 write ignored in power-down");
      do_reset("R6 R9 reset exits and clears flags");
      step(0, 1, 8'h07, 0, 8'h06, 3'b000, "R4 both requested, power-down wins");
      do_reset("R1 reset again");
      // guarded variant
      step(1, 1, 8'h01, 0, 8'h00, 3'b111, "R11 lone arm no entry");
      step(1, 1, 8'h10, 0, 8'h01, 3'b011, "R10 arm then confirm enters idle");
      step(1, 0, 8'h00, 1, 8'h00, 3'b111, "R5 guarded irq wakes");
      step(1, 1, 8'h10, 0, 8'h00, 3'b111, "R11 confirm without arm");
      step(1, 1, 8'h01, 0, 8'h00, 3'b111, "R11 arm");
      step(1, 1, 8'h04, 0, 8'h04, 3'b111, "R11 intervening write");
      step(1, 1, 8'h10, 0, 8'h00, 3'b111, "R11 late confirm rejected");
      step(1, 1, 8'h11, 0, 8'h00, 3'b111, "R11 enable and confirm together");
      step(1, 1, 8'h10, 0, 8'h00, 3'b111, "R11 confirm after bad arm");
      step(1, 1, 8'h02, 0, 8'h00, 3'b111, "R10 arm power-down");
      step(1, 1, 8'h20, 0, 8'h02, 3'b000, "R10 confirm enters power-down");
      do_reset("R1 reset guarded");
      step(1, 1, 8'h03, 0, 8'h00, 3'b111, "R12 arm both");
      step(1, 1, 8'h30, 0, 8'h02, 3'b000, "R12 confirm both, power-down wins");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule